// File: doc/BRIEF.md
# Pipeline Hazard and Exception Controller

This block makes the control decisions for a five-stage in-order pipeline: fetch, register read, execute, memory and writeback. The datapath presents the decoded fields of the instruction in register read, namely two source registers with use bits, a destination, a write bit and a load bit. It also presents a jump or taken-branch indication resolved in that stage and one exception flag for each of the first four stages. The block keeps a small shadow of the execute, memory and writeback pipeline registers (valid, write, destination, and a load bit for execute). From that shadow it chooses bypass sources for both register-file read ports and detects load-use hazards that bypassing cannot cover.

On a load-use hazard it withholds the load enables of the fetch and register-read pipeline registers and puts a bubble into execute. The next-PC guess is always PC+4. A redirect from register read switches the PC source to the branch target and turns the fetched instruction into a NOP. An exception replaces the faulting instruction, in its own stage, with a branch-style instruction that saves its PC+4 in the exception-pointer register, and the PC source becomes the handler. Every younger instruction is turned into a NOP. Only the oldest exception is taken.

Top module: `hz_ctrl`

## Requirements
- R1: After reset the shadow stages are empty: retire_we is 0, both bypass codes are 0, pc_src is 0 and both load enables are 1 when no instruction is presented.
- R2: Bypass codes per port are 0 = register file, 1 = execute, 2 = memory, 3 = writeback. A stage qualifies when it holds a valid writing instruction whose destination equals the source. The youngest qualifying stage wins, with execute ahead of memory and memory ahead of writeback.
- R3: Source register 31 always gets bypass code 0 and never causes a stall, and a destination of 31 never matches.
- R4: A valid load in execute whose destination equals a used source of a valid register-read instruction stalls the pipe. Both if_load_en and rf_load_en are 0, nop_to_ex is 1, and the execute stage is empty in the next cycle. No stall is raised when an exception in register read, execute or memory is taken.
- R5: With no redirect and no exception, pc_src is 0 (PC+4).
- R6: A redirect from a valid, unstalled register-read instruction sets pc_src to 1 (target), sets annul_if, and sets imux_if to 1 (NOP). A stalled redirect has no effect.
- R7: Instruction-mux codes are 0 = pass, 1 = NOP, 2 = exception branch. There is a mux for fetch, register read, execute and memory, and none for writeback. A taken exception sets its stage's code to 2 and pc_src to 2 (handler). The replacement retires as a write to register 30.
- R8: When an exception is taken in a stage, every earlier stage gets code 1, and the annulled instructions never retire.
- R9: The oldest exception wins over younger exceptions and over a redirect. A fetch exception is taken only with no stall, no redirect and no older exception.
- R10: Retired writes (retire_we, retire_dst) appear in program order, with stall bubbles and annulled instructions removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_valid | input | 1 | Register-read stage holds an instruction |
| rf_src_a | input | 5 | First source register |
| rf_use_a | input | 1 | First source is read |
| rf_src_b | input | 5 | Second source register |
| rf_use_b | input | 1 | Second source is read |
| rf_dst | input | 5 | Destination register |
| rf_wr | input | 1 | Instruction writes its destination |
| rf_load | input | 1 | Instruction is a load |
| rf_redirect | input | 1 | Jump or taken branch resolved in register read |
| if_exc | input | 1 | Exception raised by the fetched instruction |
| rf_exc | input | 1 | Exception raised in register read |
| ex_exc | input | 1 | Exception raised in execute |
| mem_exc | input | 1 | Exception raised in memory |
| if_load_en | output | 1 | Load enable of the fetch pipeline register |
| rf_load_en | output | 1 | Load enable of the register-read pipeline register |
| nop_to_ex | output | 1 | Insert a NOP into the execute pipeline register |
| annul_if | output | 1 | Fetched instruction is annulled |
| byp_a | output | 2 | Bypass code, first read port |
| byp_b | output | 2 | Bypass code, second read port |
| imux_if | output | 2 | Instruction mux code, fetch |
| imux_rf | output | 2 | Instruction mux code, register read |
| imux_ex | output | 2 | Instruction mux code, execute |
| imux_mem | output | 2 | Instruction mux code, memory |
| pc_src | output | 2 | Next-PC source: 0 PC+4, 1 target, 2 handler |
| retire_we | output | 1 | Writeback stage retires a register write |
| retire_dst | output | 5 | Register written at retirement |

## Verification
Two pairs of functions can land in the same cycle. An exception can meet a redirect, and an exception can meet a load-use stall. The bench drives them together on purpose: an execute or memory fault while register read signals a taken branch, a fault in two stages at once, and a fault while a load-use pair sits in execute and register read. Each cycle is judged by a behavioural model that finds the oldest faulting stage by scanning from memory backwards. Precedence shows in the mux codes and the PC source, and the retired write sequence shows whether the losing instructions really vanished.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int RW = 5;
  parameter int NTRK = 3;

  typedef enum logic [1:0] {BYP_RF = 2'd0, BYP_EX = 2'd1, BYP_MEM = 2'd2, BYP_WB = 2'd3} byp_e;
  typedef enum logic [1:0] {IM_PASS = 2'd0, IM_NOP = 2'd1, IM_EXC = 2'd2} imux_e;
  typedef enum logic [1:0] {PC_PLUS4 = 2'd0, PC_TARGET = 2'd1, PC_HANDLER = 2'd2} pcsrc_e;

  function automatic logic reg_hit(input logic live, input logic [RW-1:0] dst,
                                   input logic [RW-1:0] src, input logic [RW-1:0] zr);
    return live && (dst == src) && (src != zr);
  endfunction

  function automatic logic [1:0] mux_code(input logic here, input logic younger);
    if (here) return IM_EXC;
    if (younger) return IM_NOP;
    return IM_PASS;
  endfunction
endpackage

// File: rtl/hz_bypass.sv
module hz_bypass
  import hz_pkg::*;
#(
  parameter int ZERO_REG = 31
) (
  input  logic [NTRK-1:0]         live,
  input  logic [NTRK-1:0][RW-1:0] dst,
  input  logic [RW-1:0]           src,
  output logic [1:0]              sel
);
  localparam logic [RW-1:0] ZR = ZERO_REG[RW-1:0];

  always_comb begin
    sel = BYP_RF;
    for (int k = NTRK - 1; k >= 0; k--) begin
      if (reg_hit(live[k], dst[k], src, ZR)) sel = 2'(k + 1);
    end
  end
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
  import hz_pkg::*;
(
  input  logic       hazard,
  input  logic       redirect_req,
  input  logic       if_exc,
  input  logic       rf_exc_q,
  input  logic       ex_exc_q,
  input  logic       mem_exc_q,
  output logic       stall,
  output logic       redir,
  output logic       exc_mem,
  output logic       exc_ex,
  output logic       exc_rf,
  output logic       exc_if,
  output logic [1:0] imux_if,
  output logic [1:0] imux_rf,
  output logic [1:0] imux_ex,
  output logic [1:0] imux_mem,
  output logic [1:0] pc_src
);
  logic old_exc;

  always_comb begin
    exc_mem = mem_exc_q;
    exc_ex  = ex_exc_q && !exc_mem;
    exc_rf  = rf_exc_q && !exc_mem && !exc_ex;
    old_exc = exc_mem || exc_ex || exc_rf;
    stall   = hazard && !old_exc;
    redir   = redirect_req && !old_exc && !stall;
    exc_if  = if_exc && !old_exc && !stall && !redir;

    imux_mem = mux_code(exc_mem, 1'b0);
    imux_ex  = mux_code(exc_ex, exc_mem);
    imux_rf  = mux_code(exc_rf, exc_mem || exc_ex);
    imux_if  = mux_code(exc_if, old_exc || redir);

    if (old_exc || exc_if) pc_src = PC_HANDLER;
    else if (redir)        pc_src = PC_TARGET;
    else                   pc_src = PC_PLUS4;
  end
endmodule

// File: rtl/hz_track.sv
module hz_track
  import hz_pkg::*;
#(
  parameter int XP_REG = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rf_valid,
  input  logic                    rf_wr,
  input  logic                    rf_load,
  input  logic [RW-1:0]           rf_dst,
  input  logic                    stall,
  input  logic                    exc_rf,
  input  logic                    exc_ex,
  input  logic                    exc_mem,
  output logic [NTRK-1:0]         v_q,
  output logic [NTRK-1:0]         wr_q,
  output logic [NTRK-1:0][RW-1:0] dst_q,
  output logic                    ex_ld_q
);
  localparam logic [RW-1:0] XP = XP_REG[RW-1:0];

  logic [NTRK-1:0]         v_n, wr_n;
  logic [NTRK-1:0][RW-1:0] dst_n;
  logic                    ld_n;

  always_comb begin
    v_n   = {v_q[NTRK-2:0], rf_valid};
    wr_n  = {wr_q[NTRK-2:0], rf_wr};
    dst_n = {dst_q[NTRK-2:0], rf_dst};
    ld_n  = rf_load;
    if (exc_mem) begin
      v_n[2] = 1'b1; wr_n[2] = 1'b1; dst_n[2] = XP;
      v_n[1] = 1'b0; v_n[0] = 1'b0;
    end else if (exc_ex) begin
      v_n[1] = 1'b1; wr_n[1] = 1'b1; dst_n[1] = XP;
      v_n[0] = 1'b0;
    end else if (exc_rf) begin
      v_n[0] = 1'b1; wr_n[0] = 1'b1; dst_n[0] = XP; ld_n = 1'b0;
    end else if (stall) begin
      v_n[0] = 1'b0;
    end
    if (!v_n[0]) ld_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= '0;
      wr_q    <= '0;
      dst_q   <= '0;
      ex_ld_q <= 1'b0;
    end else begin
      v_q     <= v_n;
      wr_q    <= wr_n;
      dst_q   <= dst_n;
      ex_ld_q <= ld_n;
    end
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int ZERO_REG = 31,
  parameter int XP_REG   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rf_valid,
  input  logic [RW-1:0] rf_src_a,
  input  logic          rf_use_a,
  input  logic [RW-1:0] rf_src_b,
  input  logic          rf_use_b,
  input  logic [RW-1:0] rf_dst,
  input  logic          rf_wr,
  input  logic          rf_load,
  input  logic          rf_redirect,
  input  logic          if_exc,
  input  logic          rf_exc,
  input  logic          ex_exc,
  input  logic          mem_exc,
  output logic          if_load_en,
  output logic          rf_load_en,
  output logic          nop_to_ex,
  output logic          annul_if,
  output logic [1:0]    byp_a,
  output logic [1:0]    byp_b,
  output logic [1:0]    imux_if,
  output logic [1:0]    imux_rf,
  output logic [1:0]    imux_ex,
  output logic [1:0]    imux_mem,
  output logic [1:0]    pc_src,
  output logic          retire_we,
  output logic [RW-1:0] retire_dst
);
  localparam logic [RW-1:0] ZR = ZERO_REG[RW-1:0];
  localparam int NPORT = 2;

  logic [NTRK-1:0]          v_q, wr_q, live;
  logic [NTRK-1:0][RW-1:0]  dst_q;
  logic                     ex_ld_q;
  logic [NPORT-1:0][RW-1:0] src_arr;
  logic [NPORT-1:0]         use_arr;
  logic [NPORT-1:0][1:0]    sel_arr;
  logic [NPORT-1:0]         ld_hit;
  logic hazard, stall, redir, exc_mem, exc_ex, exc_rf, exc_if, exc_any;

  assign live    = v_q & wr_q;
  assign src_arr = {rf_src_b, rf_src_a};
  assign use_arr = {rf_use_b, rf_use_a};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    hz_bypass #(.ZERO_REG(ZERO_REG)) u_byp (
      .live (live),
      .dst  (dst_q),
      .src  (src_arr[p]),
      .sel  (sel_arr[p])
    );
    assign ld_hit[p] = use_arr[p] && reg_hit(live[0] && ex_ld_q, dst_q[0], src_arr[p], ZR);
  end

  assign hazard = rf_valid && (|ld_hit);

  hz_arbiter u_arb (
    .hazard       (hazard),
    .redirect_req (rf_redirect && rf_valid),
    .if_exc       (if_exc),
    .rf_exc_q     (rf_exc && rf_valid),
    .ex_exc_q     (ex_exc && v_q[0]),
    .mem_exc_q    (mem_exc && v_q[1]),
    .stall        (stall),
    .redir        (redir),
    .exc_mem      (exc_mem),
    .exc_ex       (exc_ex),
    .exc_rf       (exc_rf),
    .exc_if       (exc_if),
    .imux_if      (imux_if),
    .imux_rf      (imux_rf),
    .imux_ex      (imux_ex),
    .imux_mem     (imux_mem),
    .pc_src       (pc_src)
  );

  hz_track #(.XP_REG(XP_REG)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rf_valid (rf_valid),
    .rf_wr    (rf_wr),
    .rf_load  (rf_load),
    .rf_dst   (rf_dst),
    .stall    (stall),
    .exc_rf   (exc_rf),
    .exc_ex   (exc_ex),
    .exc_mem  (exc_mem),
    .v_q      (v_q),
    .wr_q     (wr_q),
    .dst_q    (dst_q),
    .ex_ld_q  (ex_ld_q)
  );

  assign exc_any    = exc_mem || exc_ex || exc_rf || exc_if;
  assign if_load_en = !stall;
  assign rf_load_en = !stall;
  assign nop_to_ex  = stall;
  assign annul_if   = (imux_if == IM_NOP);
  assign byp_a      = sel_arr[0];
  assign byp_b      = sel_arr[1];
  assign retire_we  = live[2];
  assign retire_dst = dst_q[2];
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
  import hz_pkg::*;
#(
  parameter int ZERO_REG = 31,
  parameter int XP_REG   = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          redir,
  input logic          exc_any,
  input logic          ex_valid,
  input logic [RW-1:0] rf_src_a,
  input logic [RW-1:0] rf_src_b,
  input logic [1:0]    byp_a,
  input logic [1:0]    byp_b,
  input logic          annul_if,
  input logic [1:0]    imux_if,
  input logic [1:0]    imux_rf,
  input logic [1:0]    imux_ex,
  input logic [1:0]    imux_mem,
  input logic [1:0]    pc_src,
  input logic          retire_we,
  input logic [RW-1:0] retire_dst
);
  localparam logic [RW-1:0] ZR = ZERO_REG[RW-1:0];
  localparam logic [RW-1:0] XP = XP_REG[RW-1:0];

  p_stall_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid);
  p_zero_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_src_a == ZR) |-> (byp_a == BYP_RF));
  p_zero_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_src_b == ZR) |-> (byp_b == BYP_RF));
  p_plus4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir && !exc_any) |-> (pc_src == PC_PLUS4));
  p_target_annul_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src == PC_TARGET) |-> (annul_if && imux_if == IM_NOP && !stall));
  p_handler_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (imux_if == IM_EXC || imux_rf == IM_EXC || imux_ex == IM_EXC || imux_mem == IM_EXC)
      |-> (pc_src == PC_HANDLER));
  p_mem_exc_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (imux_mem == IM_EXC) |=> (retire_we && retire_dst == XP));
  p_annul_younger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (imux_mem == IM_EXC) |-> (imux_ex == IM_NOP && imux_rf == IM_NOP && imux_if == IM_NOP));
  p_single_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imux_if == IM_EXC, imux_rf == IM_EXC, imux_ex == IM_EXC, imux_mem == IM_EXC}));
endmodule

bind hz_ctrl hz_ctrl_chk #(.ZERO_REG(ZERO_REG), .XP_REG(XP_REG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .redir      (redir),
  .exc_any    (exc_any),
  .ex_valid   (v_q[0]),
  .rf_src_a   (rf_src_a),
  .rf_src_b   (rf_src_b),
  .byp_a      (byp_a),
  .byp_b      (byp_b),
  .annul_if   (annul_if),
  .imux_if    (imux_if),
  .imux_rf    (imux_rf),
  .imux_ex    (imux_ex),
  .imux_mem   (imux_mem),
  .pc_src     (pc_src),
  .retire_we  (retire_we),
  .retire_dst (retire_dst)
);

// File: tb/hz_ctrl_test.sv
module hz_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_valid = 0, rf_use_a = 0, rf_use_b = 0, rf_wr = 0, rf_load = 0, rf_redirect = 0;
  logic if_exc = 0, rf_exc = 0, ex_exc = 0, mem_exc = 0;
  logic [4:0] rf_src_a = 0, rf_src_b = 0, rf_dst = 0;
  logic if_load_en, rf_load_en, nop_to_ex, annul_if, retire_we;
  logic [1:0] byp_a, byp_b, imux_if, imux_rf, imux_ex, imux_mem, pc_src;
  logic [4:0] retire_dst;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // model of EX (0), MEM (1), WB (2) contents
  int mv[3], mw[3], md[3], ml[3];
  // instruction currently presented to register read
  int r_v = 0, r_a = 0, r_ua = 0, r_b = 0, r_ub = 0, r_d = 0, r_w = 0, r_l = 0;

  always #10 clk = ~clk;

  hz_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_src_a(rf_src_a), .rf_use_a(rf_use_a),
    .rf_src_b(rf_src_b), .rf_use_b(rf_use_b), .rf_dst(rf_dst), .rf_wr(rf_wr), .rf_load(rf_load),
    .rf_redirect(rf_redirect), .if_exc(if_exc), .rf_exc(rf_exc), .ex_exc(ex_exc), .mem_exc(mem_exc),
    .if_load_en(if_load_en), .rf_load_en(rf_load_en), .nop_to_ex(nop_to_ex), .annul_if(annul_if),
    .byp_a(byp_a), .byp_b(byp_b), .imux_if(imux_if), .imux_rf(imux_rf), .imux_ex(imux_ex),
    .imux_mem(imux_mem), .pc_src(pc_src), .retire_we(retire_we), .retire_dst(retire_dst)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int want_byp(input int src);
    if (src == 31) return 0;
    for (int k = 0; k < 3; k++)
      if (mv[k] != 0 && mw[k] != 0 && md[k] == src) return k + 1;
    return 0;
  endfunction

  task automatic step(input int nv, input int na, input int nb, input int nd, input int nw,
                      input int nl, input int br, input int ie, input int re, input int ee,
                      input int me);
    int q[4];
    int old, exc, stl, rdr, hz, ex_imux[4], pcx, nexc;
    int nv_[3], nw_[3], nd_[3], nl_[3];
    string tg;
    @(negedge clk);
    rf_valid = r_v[0]; rf_src_a = r_a[4:0]; rf_use_a = r_ua[0]; rf_src_b = r_b[4:0];
    rf_use_b = r_ub[0]; rf_dst = r_d[4:0]; rf_wr = r_w[0]; rf_load = r_l[0];
    rf_redirect = br[0]; if_exc = ie[0]; rf_exc = re[0]; ex_exc = ee[0]; mem_exc = me[0];
    #2;
    q[0] = ie; q[1] = (re != 0 && r_v != 0); q[2] = (ee != 0 && mv[0] != 0);
    q[3] = (me != 0 && mv[1] != 0);
    nexc = q[0] + q[1] + q[2] + q[3];
    old = -1;
    for (int s = 3; s >= 1; s--) if (q[s] != 0 && old < 0) old = s;
    hz = (mv[0] != 0 && mw[0] != 0 && ml[0] != 0 && md[0] != 31 && r_v != 0 &&
          ((r_ua != 0 && md[0] == r_a) || (r_ub != 0 && md[0] == r_b)));
    stl = (hz != 0 && old < 0);
    rdr = (br != 0 && r_v != 0 && old < 0 && stl == 0);
    exc = old;
    if (exc < 0 && ie != 0 && stl == 0 && rdr == 0) exc = 0;
    for (int s = 0; s < 4; s++) begin
      if (s == exc) ex_imux[s] = 2;
      else if (exc >= 0 && s < exc) ex_imux[s] = 1;
      else if (s == 0 && rdr != 0) ex_imux[s] = 1;
      else ex_imux[s] = 0;
    end
    pcx = (exc >= 0) ? 2 : (rdr != 0 ? 1 : 0);

    chk((r_a == 31) ? "R3" : "R2", "byp_a", byp_a, want_byp(r_a));
    chk((r_b == 31) ? "R3" : "R2", "byp_b", byp_b, want_byp(r_b));
    chk("R4", "if_load_en", if_load_en, stl == 0);
    chk("R4", "rf_load_en", rf_load_en, stl == 0);
    chk("R4", "nop_to_ex", nop_to_ex, stl);
    tg = (nexc > 1 || (old >= 0 && br != 0) || (old >= 0 && ie != 0)) ? "R9" :
         (exc >= 0) ? "R8" : "R6";
    chk(tg, "annul_if", annul_if, ex_imux[0] == 1);
    chk(tg, "imux_if", imux_if, ex_imux[0]);
    chk(exc >= 1 ? tg : "R6", "imux_rf", imux_rf, ex_imux[1]);
    chk(exc >= 1 ? tg : "R7", "imux_ex", imux_ex, ex_imux[2]);
    chk(exc >= 1 ? tg : "R7", "imux_mem", imux_mem, ex_imux[3]);
    chk((exc >= 0) ? "R7" : (rdr != 0 ? "R6" : "R5"), "pc_src", pc_src, pcx);
    chk("R10", "retire_we", retire_we, (mv[2] != 0 && mw[2] != 0));
    if (mv[2] != 0 && mw[2] != 0)
      chk(md[2] == 30 ? "R7" : "R10", "retire_dst", retire_dst, md[2]);

    // advance model
    nv_[2] = mv[1]; nw_[2] = mw[1]; nd_[2] = md[1]; nl_[2] = 0;
    nv_[1] = mv[0]; nw_[1] = mw[0]; nd_[1] = md[0]; nl_[1] = 0;
    nv_[0] = r_v;   nw_[0] = r_w;   nd_[0] = r_d;   nl_[0] = r_l;
    if (old == 3) begin
      nv_[2] = 1; nw_[2] = 1; nd_[2] = 30; nv_[1] = 0; nv_[0] = 0;
    end else if (old == 2) begin
      nv_[1] = 1; nw_[1] = 1; nd_[1] = 30; nv_[0] = 0;
    end else if (old == 1) begin
      nv_[0] = 1; nw_[0] = 1; nd_[0] = 30; nl_[0] = 0;
    end else if (stl != 0) begin
      nv_[0] = 0;
    end
    for (int k = 0; k < 3; k++) begin
      mv[k] = nv_[k]; mw[k] = nw_[k]; md[k] = nd_[k]; ml[k] = (nv_[k] != 0) ? nl_[k] : 0;
    end
    if (stl == 0) begin
      if (ex_imux[0] == 1) begin
        r_v = 0; r_w = 0; r_l = 0; r_ua = 0; r_ub = 0;
      end else if (ex_imux[0] == 2) begin
        r_v = 1; r_w = 1; r_l = 0; r_d = 30; r_ua = 0; r_ub = 0; r_a = 0; r_b = 0;
      end else begin
        r_v = nv; r_a = na; r_b = nb; r_d = nd; r_w = nw; r_l = nl; r_ua = 1; r_ub = 1;
      end
    end
  endtask

  task automatic alu(input int d, input int a, input int b);
    step(1, a, b, d, 1, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic int pick(input int u);
    case (u % 6)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 31;
      4: return 30;
      default: return 4;
    endcase
  endfunction

  initial begin
    for (int k = 0; k < 3; k++) begin mv[k] = 0; mw[k] = 0; md[k] = 0; ml[k] = 0; end
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "reset retire_we", retire_we, 0);
    chk("R1", "reset byp_a", byp_a, 0);
    chk("R1", "reset pc_src", pc_src, 0);
    chk("R1", "reset if_load_en", if_load_en, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1", "empty after reset retire_we", retire_we, 0);
    chk("R1", "empty after reset byp_b", byp_b, 0);

    // bypass distances R2, priority with several producers
    alu(1, 0, 0); alu(5, 1, 1); alu(2, 0, 0); alu(6, 0, 0); alu(7, 2, 0);
    alu(3, 0, 0); alu(3, 0, 0); alu(3, 0, 0); alu(8, 3, 3);
    alu(0, 0, 0); alu(0, 0, 0); alu(0, 0, 0);
    // register 31 R3
    alu(31, 0, 0); alu(9, 31, 31); step(1, 0, 0, 31, 1, 1, 0, 0, 0, 0, 0); alu(10, 31, 0);
    alu(0, 0, 0); alu(0, 0, 0);
    // load-use stall R4, and a redirect held under stall R6
    step(1, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0); alu(11, 4, 0); alu(12, 0, 0);
    step(1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0); alu(13, 0, 0);
    // redirect R6
    alu(14, 0, 0); step(1, 0, 0, 15, 1, 0, 1, 0, 0, 0, 0); alu(16, 0, 0); alu(0, 0, 0);
    // exceptions R7 R8 R9
    alu(17, 0, 0); alu(18, 0, 0); step(1, 0, 0, 19, 1, 0, 1, 1, 0, 1, 0);
    alu(20, 0, 0); alu(21, 0, 0); step(1, 0, 0, 22, 1, 0, 1, 0, 1, 1, 1);
    alu(23, 0, 0); alu(24, 0, 0); step(1, 0, 0, 25, 1, 0, 0, 1, 0, 0, 0);
    alu(26, 0, 0); alu(27, 0, 0);
    step(1, 0, 0, 5, 1, 1, 0, 0, 0, 0, 0); alu(28, 5, 5); step(1, 0, 0, 29, 1, 0, 0, 0, 0, 1, 0);
    alu(0, 0, 0); alu(0, 0, 0); alu(0, 0, 0); alu(0, 0, 0);

    // pseudo-random mix R10
    for (int i = 0; i < 1500; i++) begin
      int u;
      u = $urandom;
      step((u % 8) != 0, pick(u >> 3), pick(u >> 6), pick(u >> 9), (u >> 12) % 4 != 0,
           (u >> 14) % 3 == 0, (u >> 16) % 7 == 0, (u >> 19) % 23 == 0, (u >> 24) % 29 == 0,
           (u >> 5) % 31 == 0, (u >> 11) % 37 == 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule